// File: doc/BRIEF.md
# Programmable Clock Output Divider and Router

This block turns a reference clock and a synthesizer clock into two routed output clocks. A post divider with a 14-bit divide value P produces a clock at the input frequency divided by 2*P, with a 50% duty cycle. It runs once on the synthesizer clock and once on the reference clock. Each output has its own source selector. The second output can take the first output, or the first output divided by two.

One multipurpose control pin passes through a two-flop synchronizer in the reference domain. A 2-bit mode input decides what the pin does:
- **Output enable:** the pin gates only the first output.
- **Power-down:** the pin gates both outputs and halts every divider.
- **Frequency select:** the pin picks one of two preset configurations while the block runs. Each preset holds P and both source selects.

Every output has its own disable style. It can float, with its pad output-enable low, or it can drive a solid low. Enable changes are applied only while the affected clock is low, so no shortened pulse reaches a pin. The configuration inputs are static ports.

Top module: `clkout_router`

## Requirements
- R1: A divide-by-2*P clock has a period of 2*P source cycles and stays high for P source cycles. A P value of 0 divides exactly as P = 1.
- R2: The output 0 source select chooses as follows: 0 = synthesizer clock divided by 2*P, 1 = raw reference clock, 2 = reference clock divided by 2*P, 3 = raw reference clock.
- R3: The output 1 source select chooses as follows: 0 = raw reference clock, 1 = reference clock divided by 2, 2 = output 0 source, 3 = output 0 source divided by 2.
- R4: The mode encoding is 0 = output enable, 1 = power-down, 2 = frequency select, 3 = pin ignored. Mode 3 keeps both outputs enabled on the high preset. A pin change takes effect no earlier than after two reference rising edges.
- R5: In output-enable mode, a low pin disables output 0 and leaves output 1 toggling at its configured period. A high pin restores output 0.
- R6: In power-down mode, a low pin disables both outputs and halts all dividers. A high pin restarts both outputs at their configured periods.
- R7: A disabled output drives its clock low. Its pad enable is 0 when the output's float bit is 1, and 1 when the float bit is 0.
- R8: In frequency-select mode, pin high selects the high preset and pin low selects the low preset. A preset change restarts the divider count at zero.
- R9: An output's enable state changes only while its source is low, so no high pulse shorter than the source's own high time appears.
- R10: During and right after reset, both pad enables are 1 and the high preset is in use, as if the pin were high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Reference clock; also clocks the control logic |
| clk_syn_i | input | 1 | Synthesizer clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| ctl_pin_i | input | 1 | Multipurpose control pin, asynchronous |
| mode_i | input | 2 | Pin function: 0 enable, 1 power-down, 2 select, 3 ignored |
| p_lo_i | input | 14 | Divide value P of the low preset |
| src0_lo_i | input | 2 | Output 0 source select of the low preset |
| src1_lo_i | input | 2 | Output 1 source select of the low preset |
| p_hi_i | input | 14 | Divide value P of the high preset |
| src0_hi_i | input | 2 | Output 0 source select of the high preset |
| src1_hi_i | input | 2 | Output 1 source select of the high preset |
| float0_i | input | 1 | Output 0 floats when disabled (1) or drives low (0) |
| float1_i | input | 1 | Output 1 floats when disabled (1) or drives low (0) |
| clk0_o | output | 1 | Output clock 0 |
| clk0_oe_o | output | 1 | Pad enable of output 0 |
| clk1_o | output | 1 | Output clock 1 |
| clk1_oe_o | output | 1 | Pad enable of output 1 |

## Verification
The hardest case to reach is a pin edge that lands while an output is high. That is the only moment a shortened pulse could escape.

The bench toggles the pin in output-enable mode with hold times spread across different phases of a divided clock. It records the narrowest high pulse seen on output 0 and compares it with P reference periods.

The power-down case is harder than it looks. The dividers halt only after both outputs have been parked low. The bench therefore checks that the outputs stay silent, and that after release both return at their configured periods.

// File: rtl/clkout_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the clock output router.
// Assumes: select and mode fields are 2 bits wide.
package clkout_pkg;

    typedef enum logic [1:0] {
        PIN_OE    = 2'd0,
        PIN_PWRDN = 2'd1,
        PIN_FSEL  = 2'd2,
        PIN_OFF   = 2'd3
    } pin_mode_e;

    typedef enum logic [1:0] {
        SRC0_SYNDIV = 2'd0,
        SRC0_REF    = 2'd1,
        SRC0_REFDIV = 2'd2,
        SRC0_REFALT = 2'd3
    } src0_e;

    typedef enum logic [1:0] {
        SRC1_REF      = 2'd0,
        SRC1_REFHALF  = 2'd1,
        SRC1_OUT0     = 2'd2,
        SRC1_OUT0HALF = 2'd3
    } src1_e;

endpackage

// File: rtl/clkout_pin_decode.sv
`timescale 1ns/1ps
// Synchronizes the control pin and decodes it by mode.
// Outputs: power run request, output 0 enable request, preset choice.
// Assumes: mode_i is static; the synchronizer flops reset to 1 (pin default high).
module clkout_pin_decode
    import clkout_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic       pin_i,
    input  logic [1:0] mode_i,
    output logic       pwr_run_o,
    output logic       en0_want_o,
    output logic       preset_hi_o
);
    logic [STAGES-1:0] sync_q;
    logic              pin_s;
    pin_mode_e         mode;

    // Shift the asynchronous pin through the synchronizer chain.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) sync_q <= '1;
        else          sync_q <= (sync_q << 1) | STAGES'(pin_i);
    end

    assign pin_s = sync_q[STAGES-1];
    assign mode  = pin_mode_e'(mode_i);

    // Decode the synchronized pin level by the selected function.
    always_comb begin
        pwr_run_o   = 1'b1;
        en0_want_o  = 1'b1;
        preset_hi_o = 1'b1;
        case (mode)
            PIN_OE:    en0_want_o  = pin_s;
            PIN_PWRDN: begin
                pwr_run_o  = pin_s;
                en0_want_o = pin_s;
            end
            PIN_FSEL:  preset_hi_o = pin_s;
            default:   ;
        endcase
    end
endmodule

// File: rtl/clkout_post_div.sv
`timescale 1ns/1ps
// Divide-by-2*P clock with 50% duty and a further divide-by-2 tap.
// P comes from one of two presets; a preset change restarts the count.
// Assumes: run_i and hi_i come from the reference domain; SYNC > 0 resynchronizes them.
module clkout_post_div #(
    parameter int PW   = 14,
    parameter int SYNC = 0
) (
    input  logic          clk_i,
    input  logic          rst_n_i,
    input  logic          run_i,
    input  logic          hi_i,
    input  logic [PW-1:0] p_lo_i,
    input  logic [PW-1:0] p_hi_i,
    output logic          div_o,
    output logic          div2_o
);
    logic          run_l, hi_l, hi_prev;
    logic [PW-1:0] p_sel, p_eff, cnt;
    logic          div_q, div2_q;

    generate
        if (SYNC > 0) begin : g_sync
            logic [SYNC-1:0] run_q, hi_q;
            // Bring run and preset choice into this clock domain.
            always_ff @(posedge clk_i) begin
                if (!rst_n_i) begin
                    run_q <= '1;
                    hi_q  <= '1;
                end else begin
                    run_q <= (run_q << 1) | SYNC'(run_i);
                    hi_q  <= (hi_q << 1) | SYNC'(hi_i);
                end
            end
            assign run_l = run_q[SYNC-1];
            assign hi_l  = hi_q[SYNC-1];
        end else begin : g_direct
            assign run_l = run_i;
            assign hi_l  = hi_i;
        end
    endgenerate

    assign p_sel = hi_l ? p_hi_i : p_lo_i;
    assign p_eff = (p_sel == '0) ? PW'(1) : p_sel;

    // Count P cycles per half period; halt and clear while not running.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            cnt     <= '0;
            div_q   <= 1'b0;
            div2_q  <= 1'b0;
            hi_prev <= 1'b1;
        end else begin
            hi_prev <= hi_l;
            if (!run_l) begin
                cnt    <= '0;
                div_q  <= 1'b0;
                div2_q <= 1'b0;
            end else if (hi_l != hi_prev) begin
                cnt <= '0;
            end else if (cnt >= p_eff - PW'(1)) begin
                cnt   <= '0;
                div_q <= ~div_q;
                if (!div_q) div2_q <= ~div2_q;
            end else begin
                cnt <= cnt + PW'(1);
            end
        end
    end

    assign div_o  = div_q;
    assign div2_o = div2_q;

    // R3: the halved tap moves only on a rising edge of the divided clock, or when halted.
    assert_half_on_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (div2_q != $past(div2_q)) |-> ($rose(div_q) || !$past(run_l)));

    // R6: a halted divider is low on the following cycle.
    assert_halt_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !run_l |=> (!div_q && !div2_q));
endmodule

// File: rtl/clkout_out_gate.sv
`timescale 1ns/1ps
// Gates one output clock and drives its pad enable.
// The enable register updates on the falling reference edge, and only while the source is low.
// Assumes: src_low_i is 1 whenever the source is low just after a falling reference edge.
module clkout_out_gate (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic want_i,
    input  logic src_low_i,
    input  logic src_i,
    input  logic float_i,
    output logic clk_o,
    output logic oe_o,
    output logic en_o
);
    logic en_q;

    // Follow the enable request only while the source sits low.
    always_ff @(negedge clk_i) begin
        if (!rst_n_i)       en_q <= 1'b1;
        else if (src_low_i) en_q <= want_i;
    end

    assign clk_o = src_i & en_q;
    assign oe_o  = en_q | ~float_i;
    assign en_o  = en_q;

    // R9: enable changes only on a low source.
    assert_switch_when_low_R9: assert property (@(negedge clk_i) disable iff (!rst_n_i)
        (en_q != $past(en_q)) |-> $past(src_low_i));
endmodule

// File: rtl/clkout_router.sv
`timescale 1ns/1ps
// Top of the clock output router: two post dividers, source muxes and two output gates.
// Assumes: configuration ports are static, apart from the preset choice made by the pin.
module clkout_router
    import clkout_pkg::*;
#(
    parameter int PW       = 14,
    parameter int SYNC_LEN = 2
) (
    input  logic          clk_ref_i,
    input  logic          clk_syn_i,
    input  logic          rst_n_i,
    input  logic          ctl_pin_i,
    input  logic [1:0]    mode_i,
    input  logic [PW-1:0] p_lo_i,
    input  logic [1:0]    src0_lo_i,
    input  logic [1:0]    src1_lo_i,
    input  logic [PW-1:0] p_hi_i,
    input  logic [1:0]    src0_hi_i,
    input  logic [1:0]    src1_hi_i,
    input  logic          float0_i,
    input  logic          float1_i,
    output logic          clk0_o,
    output logic          clk0_oe_o,
    output logic          clk1_o,
    output logic          clk1_oe_o
);
    localparam int NOUT = 2;

    logic            pwr_run, en0_want, preset_hi, run_q;
    logic            ref_div, ref_div2, syn_div, syn_div2, ref_half;
    logic            src0, lvl0, half0, src1, lvl1;
    src0_e           sel0;
    src1_e           sel1;
    logic [NOUT-1:0] want, low, srcv, flt, clkv, oev, env;

    clkout_pin_decode #(.STAGES(SYNC_LEN)) u_decode (
        .clk_i       (clk_ref_i),
        .rst_n_i     (rst_n_i),
        .pin_i       (ctl_pin_i),
        .mode_i      (mode_i),
        .pwr_run_o   (pwr_run),
        .en0_want_o  (en0_want),
        .preset_hi_o (preset_hi)
    );

    // Keep the dividers running until both outputs are parked.
    always_ff @(posedge clk_ref_i) begin
        if (!rst_n_i) run_q <= 1'b1;
        else          run_q <= pwr_run | env[0] | env[1];
    end

    // Reference clock divided by two.
    always_ff @(posedge clk_ref_i) begin
        if (!rst_n_i || !run_q) ref_half <= 1'b0;
        else                    ref_half <= ~ref_half;
    end

    clkout_post_div #(.PW(PW), .SYNC(0)) u_ref_div (
        .clk_i (clk_ref_i), .rst_n_i (rst_n_i), .run_i (run_q), .hi_i (preset_hi),
        .p_lo_i (p_lo_i), .p_hi_i (p_hi_i), .div_o (ref_div), .div2_o (ref_div2)
    );

    clkout_post_div #(.PW(PW), .SYNC(SYNC_LEN)) u_syn_div (
        .clk_i (clk_syn_i), .rst_n_i (rst_n_i), .run_i (run_q), .hi_i (preset_hi),
        .p_lo_i (p_lo_i), .p_hi_i (p_hi_i), .div_o (syn_div), .div2_o (syn_div2)
    );

    assign sel0 = src0_e'(preset_hi ? src0_hi_i : src0_lo_i);
    assign sel1 = src1_e'(preset_hi ? src1_hi_i : src1_lo_i);

    // Output 0 source, its gating level (raw clock counts as low) and its halved tap.
    always_comb begin
        case (sel0)
            SRC0_SYNDIV: begin src0 = syn_div;   lvl0 = syn_div; half0 = syn_div2; end
            SRC0_REFDIV: begin src0 = ref_div;   lvl0 = ref_div; half0 = ref_div2; end
            default:     begin src0 = clk_ref_i; lvl0 = 1'b0;    half0 = ref_half; end
        endcase
    end

    // Output 1 source and its gating level.
    always_comb begin
        case (sel1)
            SRC1_REFHALF:  begin src1 = ref_half;  lvl1 = ref_half; end
            SRC1_OUT0:     begin src1 = src0;      lvl1 = lvl0;     end
            SRC1_OUT0HALF: begin src1 = half0;     lvl1 = half0;    end
            default:       begin src1 = clk_ref_i; lvl1 = 1'b0;     end
        endcase
    end

    assign want = {pwr_run, en0_want};
    assign low  = {~lvl1, ~lvl0};
    assign srcv = {src1, src0};
    assign flt  = {float1_i, float0_i};

    generate
        for (genvar i = 0; i < NOUT; i++) begin : g_out
            clkout_out_gate u_gate (
                .clk_i (clk_ref_i), .rst_n_i (rst_n_i), .want_i (want[i]),
                .src_low_i (low[i]), .src_i (srcv[i]), .float_i (flt[i]),
                .clk_o (clkv[i]), .oe_o (oev[i]), .en_o (env[i])
            );
        end
    endgenerate

    assign clk0_o    = clkv[0];
    assign clk1_o    = clkv[1];
    assign clk0_oe_o = oev[0];
    assign clk1_oe_o = oev[1];

    // R5: in output-enable mode, an enabled output 1 stays enabled.
    assert_oe_keeps_out1_R5: assert property (@(posedge clk_ref_i) disable iff (!rst_n_i)
        (mode_i == 2'(PIN_OE) && $past(mode_i) == 2'(PIN_OE) && $past(env[1])) |-> env[1]);
endmodule

// File: tb/clkout_router_bench.sv
`timescale 1ns/1ps
// Bench for clkout_router: a table of period vectors, then directed mode and corner tests.
module clkout_router_bench;
    logic        clk_ref = 1'b0, clk_syn = 1'b0, rst_n = 1'b0, pin = 1'b1;
    logic [1:0]  mode = 2'd3;
    logic [13:0] p_lo = 14'd2, p_hi = 14'd3;
    logic [1:0]  s0_lo = 2'd2, s1_lo = 2'd0, s0_hi = 2'd2, s1_hi = 2'd0;
    logic        flt0 = 1'b1, flt1 = 1'b1;
    logic        clk0, oe0, clk1, oe1;

    int unsigned n_chk = 0, n_fail = 0, rise0 = 0, rise1 = 0;
    realtime     last_r0 = 0.0, min_hi0 = 1.0e9;

    always #2   clk_ref = ~clk_ref;   // 250 MHz reference
    always #3   clk_syn = ~clk_syn;   // 6 ns synthesizer clock

    clkout_router u_clkout_router (
        .clk_ref_i (clk_ref), .clk_syn_i (clk_syn), .rst_n_i (rst_n), .ctl_pin_i (pin),
        .mode_i (mode), .p_lo_i (p_lo), .src0_lo_i (s0_lo), .src1_lo_i (s1_lo),
        .p_hi_i (p_hi), .src0_hi_i (s0_hi), .src1_hi_i (s1_hi),
        .float0_i (flt0), .float1_i (flt1),
        .clk0_o (clk0), .clk0_oe_o (oe0), .clk1_o (clk1), .clk1_oe_o (oe1)
    );

    always @(posedge clk0) begin rise0++; last_r0 = $realtime; end
    always @(posedge clk1) rise1++;
    always @(negedge clk0) if ($realtime - last_r0 < min_hi0) min_hi0 = $realtime - last_r0;

    // Vectors: P, output 0 select, output 1 select, period 0 (ns), period 1 (ns).
    localparam int NV = 8;
    localparam int VEC [NV][5] = '{
        '{3, 2, 0, 24, 4},
        '{5, 0, 1, 60, 8},
        '{1, 2, 3, 8, 16},
        '{0, 2, 2, 8, 8},
        '{2, 1, 3, 4, 8},
        '{4, 0, 3, 48, 96},
        '{7, 2, 2, 56, 56},
        '{2, 3, 1, 4, 8}
    };

    task automatic chk(input string req, input string what, input real act, input real exp);
        n_chk++;
        if (act - exp > 0.01 || exp - act > 0.01) begin
            n_fail++;
            $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk_ref);
        #1;
    endtask

    task automatic meas(input int which, output real per);
        realtime a;
        if (which == 0) begin
            @(posedge clk0); a = $realtime; @(posedge clk0);
        end else begin
            @(posedge clk1); a = $realtime; @(posedge clk1);
        end
        per = $realtime - a;
        #0.5;
    endtask

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        real per, hi;
        int unsigned r0, r1;
        step(5);
        chk("R10", "oe0 in reset", real'(oe0), 1.0);
        chk("R10", "oe1 in reset", real'(oe1), 1.0);
        rst_n = 1'b1;
        step(3);
        chk("R10", "oe0 after reset", real'(oe0), 1.0);
        chk("R10", "oe1 after reset", real'(oe1), 1.0);

        // R1 R2 R3: period table under mode 3, high preset
        for (int v = 0; v < NV; v++) begin
            p_hi = 14'(VEC[v][0]); s0_hi = 2'(VEC[v][1]); s1_hi = 2'(VEC[v][2]);
            step(60);
            meas(0, per); chk("R1/R2", $sformatf("vec%0d period0", v), per, real'(VEC[v][3]));
            meas(1, per); chk("R3", $sformatf("vec%0d period1", v), per, real'(VEC[v][4]));
        end

        // R1: duty cycle, P = 3 gives 12 ns high
        p_hi = 14'd3; s0_hi = 2'd2; s1_hi = 2'd1;
        step(40);
        @(posedge clk0); hi = $realtime; @(negedge clk0); hi = $realtime - hi;
        chk("R1", "high time", hi, 12.0);

        // R4: synchronizer delay in output-enable mode, raw reference source
        mode = 2'd0; s0_hi = 2'd1; step(10);
        pin = 1'b0; step(1);
        chk("R4", "oe0 one edge after pin low", real'(oe0), 1.0);
        step(2);
        chk("R4", "oe0 after sync", real'(oe0), 0.0);
        pin = 1'b1; step(10);

        // R5 R7: output enable gates only output 0
        p_hi = 14'd2; s0_hi = 2'd2; s1_hi = 2'd1; step(40);
        pin = 1'b0; step(20);
        r0 = rise0; r1 = rise1; step(40);
        chk("R5", "clk0 edges while off", real'(rise0 - r0), 0.0);
        chk("R5", "clk1 still toggles", real'(rise1 - r1 >= 15), 1.0);
        chk("R7", "oe0 floating", real'(oe0), 0.0);
        chk("R5", "oe1 stays on", real'(oe1), 1.0);
        flt0 = 1'b0; step(2);
        chk("R7", "oe0 driven low", real'(oe0), 1.0);
        chk("R7", "clk0 held low", real'(clk0), 0.0);
        meas(1, per); chk("R5", "clk1 period while out0 off", per, 8.0);
        pin = 1'b1; step(20);
        meas(0, per); chk("R5", "clk0 restored", per, 16.0);

        // R6 R7: power-down gates both and halts dividers
        mode = 2'd1; flt0 = 1'b1; flt1 = 1'b0; step(10);
        pin = 1'b0; step(40);
        r0 = rise0; r1 = rise1; step(40);
        chk("R6", "clk0 edges in power-down", real'(rise0 - r0), 0.0);
        chk("R6", "clk1 edges in power-down", real'(rise1 - r1), 0.0);
        chk("R7", "oe0 floating", real'(oe0), 0.0);
        chk("R7", "oe1 driven low", real'(oe1), 1.0);
        chk("R6", "clk1 low", real'(clk1), 0.0);
        pin = 1'b1; step(40);
        meas(0, per); chk("R6", "clk0 after wake", per, 16.0);
        meas(1, per); chk("R6", "clk1 after wake", per, 8.0);

        // R8: frequency select between presets
        mode = 2'd2; flt1 = 1'b1;
        p_lo = 14'd2; s0_lo = 2'd2; s1_lo = 2'd2;
        p_hi = 14'd6; s0_hi = 2'd2; s1_hi = 2'd2;
        step(60);
        meas(0, per); chk("R8", "high preset period0", per, 48.0);
        pin = 1'b0; step(60);
        meas(0, per); chk("R8", "low preset period0", per, 16.0);
        meas(1, per); chk("R8", "low preset period1", per, 16.0);
        pin = 1'b1; step(60);
        meas(0, per); chk("R8", "back to high preset", per, 48.0);

        // R4: mode 3 ignores a low pin
        mode = 2'd3; pin = 1'b0; step(60);
        meas(0, per); chk("R4", "pin ignored period0", per, 48.0);
        chk("R4", "pin ignored oe0", real'(oe0), 1.0);
        chk("R4", "pin ignored oe1", real'(oe1), 1.0);

        // R9: pin toggles at varied phases never shorten a high pulse
        pin = 1'b1; mode = 2'd0; p_hi = 14'd3; s0_hi = 2'd2; step(40);
        min_hi0 = 1.0e9;
        for (int k = 0; k < 24; k++) begin
            pin = ~pin;
            step(k % 7 + 1);
        end
        pin = 1'b1; step(40);
        meas(0, per);
        chk("R9", "narrowest clk0 high pulse", min_hi0, 12.0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule